// File: doc/BRIEF.md
# Event Mapping Command Handler

This block executes the two commands that bind one event of a device to an interrupt number and a collection. A start strobe hands it the address of a command in the command queue. The block reads the three 64-bit words of that command through a shared memory port. It then asks an external table walker, through a lookup port, for the device's table entry: a valid flag, a size field and the base address of the device's translation table. It range-checks the fields and, when every check passes, writes a two-word translation entry into that table.

A mode input selects one of two forms. In the explicit form the interrupt number comes from the command. In the implicit form the event number doubles as the interrupt number, and no interrupt-number range check is made. A command that fails a check is discarded without any write. Each command ends with a one-cycle done pulse carrying a status code: 0 written, 1 discarded, 2 memory or lookup error.

Top module: `emap_cmd_top`

## Requirements
- R1: The command words are read in order, as wide reads at `cmd_addr`, `cmd_addr+8` and `cmd_addr+16`. The device number is word 0 bits [63:32], the event number is word 1 bits [31:0], the interrupt number is word 1 bits [63:32], and the collection number is word 2 bits [15:0].
- R2: If any command-word read returns an error, the command ends with status 2. No further read, no lookup and no write follows.
- R3: After the three reads, exactly one lookup is made with the device number on `lk_devid`. A lookup error ends the command with status 2 and no write.
- R4: The command is discarded (status 1, no write) if any of these holds: the device number exceeds MAX_DEVID, the collection number exceeds MAX_COLLID, the looked-up entry is invalid, or the event number exceeds 2^(size+1).
- R5: In the explicit form (`implicit_id`=0), the command is discarded if the interrupt number is below 8192 or above 2^(id_bits+1). In the implicit form, word 1 bits [63:32] have no effect.
- R6: The low entry word is a wide write to base + event×8. Its bit 0 is 1 (valid), bit 1 is 1 (physical), bits [25:2] hold the interrupt number's low 24 bits (the event number in the implicit form), bits [35:26] hold 1023, and all other bits are 0.
- R7: The high entry word is a narrow (32-bit) write to base + event×4 + 32 holding the collection number zero-extended. It is issued only after the low write completes without error. An error on either write gives status 2.
- R8: `done` is a one-cycle pulse, with status 0 after a successful high write. A `start` while a command is in progress is ignored.
- R9: After reset, `done`, `mem_req` and `lk_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (accepted when idle) |
| cmd_addr | input | AW | Address of command word 0 |
| implicit_id | input | 1 | 1: event number used as interrupt number |
| id_bits | input | 5 | Configured interrupt-number bits field |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 written, 1 discarded, 2 error; valid with done |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 write, 0 read |
| mem_wide | output | 1 | 1 for a 64-bit access, 0 for a 32-bit access |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 64 | Write data (low 32 bits for narrow writes) |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed, valid with mem_ack |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| lk_req | output | 1 | Device-entry lookup request |
| lk_devid | output | 32 | Device number to look up |
| lk_ack | input | 1 | Lookup complete |
| lk_err | input | 1 | Lookup failed |
| lk_valid | input | 1 | Device entry valid |
| lk_size | input | 5 | Device entry size field |
| lk_base | input | AW | Device translation table base |

## Verification
The bench aims at the inclusive edges of every range check. It uses an event number equal to 2^(size+1) and one past it, interrupt numbers 8191, 8192, 2^(id_bits+1) and one past it, and device and collection numbers at their maximum and one above. An off-by-one comparison would discard a legal command or write an illegal one. Errors are injected on each of the five memory accesses and on the lookup. A design that kept going after an error would show extra reads, a lookup, or a high write after a failed low write. Implicit commands carry a garbage interrupt field, which would cause discards or a wrong stored number if the field leaked through. A second start mid-command checks that no extra reads appear.

// File: rtl/emap_pkg.sv
package emap_pkg;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_DROP = 2'd1,
    ST_ERR  = 2'd2
  } emap_status_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_RD2, S_LOOK, S_CHECK, S_WRLO, S_WRHI, S_DONE
  } emap_state_e;

  localparam int unsigned SPURIOUS_ID = 1023;
  localparam int unsigned LPI_FLOOR   = 8192;

  typedef struct packed {
    logic [31:0] devid;
    logic [31:0] event_id;
    logic [31:0] intid;
    logic [15:0] collid;
  } emap_cmd_t;

endpackage

// File: rtl/emap_check.sv
module emap_check
  import emap_pkg::*;
#(
  parameter logic [31:0] MAX_DEVID  = 32'h0000_FFFF,
  parameter logic [15:0] MAX_COLLID = 16'h00FF
) (
  input  emap_cmd_t   cmd,
  input  logic        implicit_id,
  input  logic [4:0]  id_bits,
  input  logic        dte_valid,
  input  logic [4:0]  dte_size,
  output logic        accept
);

  logic [33:0] evt_limit;
  logic [33:0] int_limit;
  logic        base_ok;
  logic        int_ok;

  always_comb begin
    evt_limit = 34'd2 << dte_size;
    int_limit = 34'd2 << id_bits;
    base_ok   = (cmd.devid <= MAX_DEVID) && (cmd.collid <= MAX_COLLID) &&
                dte_valid && ({2'b00, cmd.event_id} <= evt_limit);
    int_ok    = implicit_id ||
                ((cmd.intid >= 32'(LPI_FLOOR)) && ({2'b00, cmd.intid} <= int_limit));
    accept    = base_ok && int_ok;
  end

endmodule

// File: rtl/emap_pack.sv
module emap_pack
  import emap_pkg::*;
#(
  parameter int unsigned AW = 48
) (
  input  logic [31:0]   event_id,
  input  logic [23:0]   intid_lo,
  input  logic [15:0]   collid,
  input  logic          implicit_id,
  input  logic [AW-1:0] table_base,
  output logic [63:0]   lo_word,
  output logic [31:0]   hi_word,
  output logic [AW-1:0] lo_addr,
  output logic [AW-1:0] hi_addr
);

  localparam logic [9:0] SPUR = 10'(SPURIOUS_ID);

  logic [23:0] stored_id;

  always_comb begin
    stored_id = implicit_id ? event_id[23:0] : intid_lo;
    lo_word   = {28'd0, SPUR, stored_id, 1'b1, 1'b1};
    hi_word   = {16'd0, collid};
    lo_addr   = table_base + AW'({event_id, 3'b000});
    hi_addr   = table_base + AW'({event_id, 2'b00}) + AW'(32);
  end

endmodule

// File: rtl/emap_cmd_top.sv
module emap_cmd_top
  import emap_pkg::*;
#(
  parameter int unsigned AW         = 48,
  parameter logic [31:0] MAX_DEVID  = 32'h0000_FFFF,
  parameter logic [15:0] MAX_COLLID = 16'h00FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cmd_addr,
  input  logic          implicit_id,
  input  logic [4:0]    id_bits,
  output logic          done,
  output logic [1:0]    status,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_wide,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [63:0]   mem_rdata,
  output logic          lk_req,
  output logic [31:0]   lk_devid,
  input  logic          lk_ack,
  input  logic          lk_err,
  input  logic          lk_valid,
  input  logic [4:0]    lk_size,
  input  logic [AW-1:0] lk_base
);

  emap_state_e  state_q, state_d;
  emap_status_e status_q, status_d;
  emap_cmd_t    cmd_q;
  logic [AW-1:0] addr_q;
  logic          impl_q;
  logic [4:0]    idb_q;
  logic          dval_q;
  logic [4:0]    dsize_q;
  logic [AW-1:0] base_q;
  logic          lo_ok_q;

  logic en_start, en_w0, en_w1, en_w2, en_lk, en_lo;
  logic          accept;
  logic [63:0]   lo_word;
  logic [31:0]   hi_word;
  logic [AW-1:0] lo_addr, hi_addr;
  logic          ok_ack;

  emap_check #(.MAX_DEVID(MAX_DEVID), .MAX_COLLID(MAX_COLLID)) i_check (
    .cmd(cmd_q), .implicit_id(impl_q), .id_bits(idb_q),
    .dte_valid(dval_q), .dte_size(dsize_q), .accept(accept)
  );

  emap_pack #(.AW(AW)) i_pack (
    .event_id(cmd_q.event_id), .intid_lo(cmd_q.intid[23:0]), .collid(cmd_q.collid),
    .implicit_id(impl_q), .table_base(base_q),
    .lo_word(lo_word), .hi_word(hi_word), .lo_addr(lo_addr), .hi_addr(hi_addr)
  );

  assign ok_ack = mem_ack && !mem_err;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    en_start = 1'b0;
    en_w0    = 1'b0;
    en_w1    = 1'b0;
    en_w2    = 1'b0;
    en_lk    = 1'b0;
    en_lo    = 1'b0;
    case (state_q)
      S_IDLE: if (start) begin
        en_start = 1'b1;
        state_d  = S_RD0;
      end
      S_RD0: if (mem_ack) begin
        en_w0   = !mem_err;
        state_d = mem_err ? S_DONE : S_RD1;
        if (mem_err) status_d = ST_ERR;
      end
      S_RD1: if (mem_ack) begin
        en_w1   = !mem_err;
        state_d = mem_err ? S_DONE : S_RD2;
        if (mem_err) status_d = ST_ERR;
      end
      S_RD2: if (mem_ack) begin
        en_w2   = !mem_err;
        state_d = mem_err ? S_DONE : S_LOOK;
        if (mem_err) status_d = ST_ERR;
      end
      S_LOOK: if (lk_ack) begin
        en_lk   = !lk_err;
        state_d = lk_err ? S_DONE : S_CHECK;
        if (lk_err) status_d = ST_ERR;
      end
      S_CHECK: begin
        state_d = accept ? S_WRLO : S_DONE;
        if (!accept) status_d = ST_DROP;
      end
      S_WRLO: if (mem_ack) begin
        en_lo   = !mem_err;
        state_d = mem_err ? S_DONE : S_WRHI;
        if (mem_err) status_d = ST_ERR;
      end
      S_WRHI: if (mem_ack) begin
        state_d  = S_DONE;
        status_d = mem_err ? ST_ERR : ST_OK;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      status_q <= ST_OK;
      lo_ok_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
      if (en_start)   lo_ok_q <= 1'b0;
      else if (en_lo) lo_ok_q <= 1'b1;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      addr_q  <= '0;
      impl_q  <= 1'b0;
      idb_q   <= '0;
      dval_q  <= 1'b0;
      dsize_q <= '0;
      base_q  <= '0;
    end else begin
      if (en_start) begin
        addr_q <= cmd_addr;
        impl_q <= implicit_id;
        idb_q  <= id_bits;
      end
      if (en_w0) cmd_q.devid <= mem_rdata[63:32];
      if (en_w1) begin
        cmd_q.event_id <= mem_rdata[31:0];
        cmd_q.intid    <= mem_rdata[63:32];
      end
      if (en_w2) cmd_q.collid <= mem_rdata[15:0];
      if (en_lk) begin
        dval_q  <= lk_valid;
        dsize_q <= lk_size;
        base_q  <= lk_base;
      end
    end
  end

  // outputs
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_wide  = 1'b1;
    mem_addr  = addr_q;
    mem_wdata = '0;
    case (state_q)
      S_RD0: mem_req = 1'b1;
      S_RD1: begin mem_req = 1'b1; mem_addr = addr_q + AW'(8);  end
      S_RD2: begin mem_req = 1'b1; mem_addr = addr_q + AW'(16); end
      S_WRLO: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = lo_addr; mem_wdata = lo_word;
      end
      S_WRHI: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_wide = 1'b0;
        mem_addr = hi_addr; mem_wdata = {32'd0, hi_word};
      end
      default: ;
    endcase
  end

  assign lk_req   = (state_q == S_LOOK);
  assign lk_devid = cmd_q.devid;
  assign done     = (state_q == S_DONE);
  assign status   = status_q;

  // R1: a pending memory request keeps its address until acknowledged
  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R3: lookup request holds its device number until acknowledged
  p_lk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req && !lk_ack |=> lk_req && $stable(lk_devid));

  // R2: a failed read is never followed by any further request
  p_err_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack && mem_err |=> !mem_req && !lk_req);

  // R6: every wide write carries the valid, physical and spurious fields
  p_lo_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_wide |->
      mem_wdata[1:0] == 2'b11 && mem_wdata[35:26] == 10'd1023 && mem_wdata[63:36] == '0);

  // R7: the narrow write only after a clean low write
  p_hi_after_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_wide |-> lo_ok_q);

  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: requests never overlap
  p_one_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, lk_req, done}));

endmodule

// File: tb/test_emap_cmd_top.sv
module test_emap_cmd_top;

  localparam int unsigned AW         = 48;
  localparam logic [31:0] MAX_DEVID  = 32'h0000_FFFF;
  localparam logic [15:0] MAX_COLLID = 16'h00FF;

  logic          clk, rst_n, start, implicit_id;
  logic [AW-1:0] cmd_addr;
  logic [4:0]    id_bits;
  logic          done;
  logic [1:0]    status;
  logic          mem_req, mem_we, mem_wide, mem_ack, mem_err;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata, mem_rdata;
  logic          lk_req, lk_ack, lk_err, lk_valid;
  logic [31:0]   lk_devid;
  logic [4:0]    lk_size;
  logic [AW-1:0] lk_base;

  emap_cmd_top #(.AW(AW), .MAX_DEVID(MAX_DEVID), .MAX_COLLID(MAX_COLLID)) i_emap_cmd_top (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_addr(cmd_addr),
    .implicit_id(implicit_id), .id_bits(id_bits), .done(done), .status(status),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .lk_req(lk_req), .lk_devid(lk_devid), .lk_ack(lk_ack), .lk_err(lk_err),
    .lk_valid(lk_valid), .lk_size(lk_size), .lk_base(lk_base)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // scenario state
  logic [63:0]   w0, w1, w2;
  logic          m_valid, m_lkerr;
  logic [4:0]    m_size;
  logic [AW-1:0] m_base;
  int            err_at;
  int            acc_idx, n_rd, n_wr, n_lk;
  logic [AW-1:0] rd_addr [3];
  logic [AW-1:0] lo_a, hi_a;
  logic [63:0]   lo_d, hi_d;
  logic          lo_w, hi_w;
  logic [31:0]   seen_devid;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory and lookup responder
  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      mem_ack = 0; mem_err = 0; mem_rdata = '0; lk_ack = 0; lk_err = 0;
    end else begin
      if (mem_ack) begin
        mem_ack = 0; mem_err = 0;
      end else if (mem_req) begin
        acc_idx++;
        mem_ack = 1;
        mem_err = (acc_idx == err_at);
        if (!mem_we) begin
          if (n_rd < 3) rd_addr[n_rd] = mem_addr;
          n_rd++;
          case ((mem_addr - cmd_addr) >> 3)
            0: mem_rdata = w0;
            1: mem_rdata = w1;
            2: mem_rdata = w2;
            default: mem_rdata = '0;
          endcase
        end else begin
          n_wr++;
          if (mem_wide) begin lo_w = 1; lo_a = mem_addr; lo_d = mem_wdata; end
          else begin hi_w = 1; hi_a = mem_addr; hi_d = mem_wdata; end
        end
      end
      if (lk_ack) begin
        lk_ack = 0; lk_err = 0;
      end else if (lk_req) begin
        n_lk++;
        seen_devid = lk_devid;
        lk_ack = 1; lk_err = m_lkerr;
        lk_valid = m_valid; lk_size = m_size; lk_base = m_base;
      end
    end
  end

  function automatic logic accept_ref(input logic [31:0] dev, input logic [31:0] ev,
                                      input logic [31:0] iid, input logic [15:0] col,
                                      input logic impl, input logic [4:0] idb,
                                      input logic v, input logic [4:0] sz);
    logic [33:0] el, il;
    el = 34'd1 << (sz + 6'd1);
    il = 34'd1 << (idb + 6'd1);
    if (dev > MAX_DEVID || col > MAX_COLLID || !v || {2'b0, ev} > el) return 1'b0;
    if (!impl && (iid < 32'd8192 || {2'b0, iid} > il)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic run(input logic [31:0] dev, input logic [31:0] ev, input logic [31:0] iid,
                     input logic [15:0] col, input logic impl, input logic [4:0] idb,
                     input logic v, input logic [4:0] sz, input int e_at, input logic le,
                     input logic busy_start);
    int waitc;
    logic [1:0] got_st;
    logic [1:0] exp_st;
    int exp_rd, exp_lk, exp_wr;
    logic [AW-1:0] b;
    b = {$urandom, $urandom} & {{(AW-8){1'b1}}, 8'h00};
    b[AW-1] = 1'b0;
    w0 = {dev, $urandom};
    w1 = {iid, ev};
    w2 = {$urandom, $urandom} & 64'hFFFF_FFFF_FFFF_0000 | {48'd0, col};
    m_valid = v; m_size = sz; m_base = b; m_lkerr = le; err_at = e_at;
    acc_idx = 0; n_rd = 0; n_wr = 0; n_lk = 0; lo_w = 0; hi_w = 0; seen_devid = '0;
    @(negedge clk);
    cmd_addr = {$urandom, $urandom} & {{(AW-4){1'b0}}, 4'h0} | AW'({$urandom} & 32'hFFFF_FFF0);
    implicit_id = impl; id_bits = idb; start = 1;
    @(negedge clk);
    start = 0;
    if (busy_start) begin
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
    end
    waitc = 0;
    while (!done && waitc < 200) begin @(negedge clk); waitc++; end
    got_st = status;
    chk("R8 done seen", done, 1'b1);
    @(negedge clk);
    chk("R8 done one cycle", done, 1'b0);
    // expected
    exp_wr = 0; exp_lk = 0;
    if (e_at >= 1 && e_at <= 3) begin exp_rd = e_at; exp_st = 2; end
    else begin
      exp_rd = 3; exp_lk = 1;
      if (le) exp_st = 2;
      else if (!accept_ref(dev, ev, iid, col, impl, idb, v, sz)) exp_st = 1;
      else if (e_at == 4) begin exp_wr = 1; exp_st = 2; end
      else begin exp_wr = 2; exp_st = (e_at == 5) ? 2'd2 : 2'd0; end
    end
    chk("R2/R4 status", got_st, exp_st);
    chk("R2 read count", n_rd, exp_rd);
    chk("R3 lookup count", n_lk, exp_lk);
    chk("R7 write count", n_wr, exp_wr);
    for (int k = 0; k < exp_rd; k++) chk("R1 read order", rd_addr[k], cmd_addr + AW'(8 * k));
    if (exp_lk == 1) chk("R3 lookup devid", seen_devid, dev);
    if (exp_wr >= 1) begin
      chk("R6 low addr", lo_a, b + AW'({ev, 3'b000}));
      chk("R6 low data", lo_d, {28'd0, 10'd1023, (impl ? ev[23:0] : iid[23:0]), 2'b11});
    end
    if (exp_wr == 2) begin
      chk("R7 high addr", hi_a, b + AW'({ev, 2'b00}) + AW'(32));
      chk("R7 high data", hi_d[31:0], {16'd0, col});
    end
  endtask

  initial begin
    void'($urandom(32'd77));
    rst_n = 0; start = 0; cmd_addr = '0; implicit_id = 0; id_bits = 5'd15;
    lk_valid = 0; lk_size = 0; lk_base = '0;
    m_lkerr = 0; m_valid = 1; m_size = 0; m_base = '0; err_at = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset done", done, 1'b0);
    chk("R9 reset mem_req", mem_req, 1'b0);
    chk("R9 reset lk_req", lk_req, 1'b0);
    rst_n = 1;
    @(negedge clk);
    // directed: R4 event boundary (size 3 -> limit 16)
    run(32'd5, 32'd16, 32'd9000, 16'd3, 0, 5'd15, 1, 5'd3, 0, 0, 0);
    run(32'd5, 32'd17, 32'd9000, 16'd3, 0, 5'd15, 1, 5'd3, 0, 0, 0);
    // R4 device / collection limits, invalid entry
    run(MAX_DEVID, 32'd1, 32'd9000, MAX_COLLID, 0, 5'd15, 1, 5'd3, 0, 0, 0);
    run(MAX_DEVID + 1, 32'd1, 32'd9000, 16'd0, 0, 5'd15, 1, 5'd3, 0, 0, 0);
    run(32'd1, 32'd1, 32'd9000, MAX_COLLID + 1, 0, 5'd15, 1, 5'd3, 0, 0, 0);
    run(32'd1, 32'd1, 32'd9000, 16'd2, 0, 5'd15, 0, 5'd3, 0, 0, 0);
    // R5 interrupt range (id_bits 14 -> limit 32768)
    run(32'd2, 32'd3, 32'd8191, 16'd1, 0, 5'd14, 1, 5'd4, 0, 0, 0);
    run(32'd2, 32'd3, 32'd8192, 16'd1, 0, 5'd14, 1, 5'd4, 0, 0, 0);
    run(32'd2, 32'd3, 32'd32768, 16'd1, 0, 5'd14, 1, 5'd4, 0, 0, 0);
    run(32'd2, 32'd3, 32'd32769, 16'd1, 0, 5'd14, 1, 5'd4, 0, 0, 0);
    // R5 implicit form ignores garbage interrupt field
    run(32'd2, 32'd7, 32'hFFFF_FFFF, 16'd1, 1, 5'd14, 1, 5'd4, 0, 0, 0);
    run(32'd2, 32'd7, 32'd0, 16'd9, 1, 5'd14, 1, 5'd4, 0, 0, 0);
    // R2 / R3 / R7 error injection
    for (int e = 1; e <= 5; e++) run(32'd4, 32'd2, 32'd9000, 16'd5, 0, 5'd15, 1, 5'd3, e, 0, 0);
    run(32'd4, 32'd2, 32'd9000, 16'd5, 0, 5'd15, 1, 5'd3, 0, 1, 0);
    // R8 start while busy ignored
    run(32'd4, 32'd2, 32'd9000, 16'd5, 0, 5'd15, 1, 5'd3, 0, 0, 1);
    // random
    for (int i = 0; i < 60; i++) begin
      logic [4:0] sz, idb;
      logic [31:0] ev, iid, dev;
      logic [15:0] col;
      logic impl, v, le;
      int ea;
      sz  = 5'($urandom % 6);
      idb = 5'(13 + $urandom % 6);
      ev  = $urandom % ((32'd1 << (sz + 1)) + 3);
      case ($urandom % 5)
        0: iid = 32'd8191;
        1: iid = 32'd8192;
        2: iid = 32'd1 << (idb + 1);
        3: iid = (32'd1 << (idb + 1)) + 1;
        default: iid = 32'd8192 + $urandom % 4096;
      endcase
      case ($urandom % 4)
        0: dev = MAX_DEVID;
        1: dev = MAX_DEVID + 1;
        default: dev = $urandom % 1000;
      endcase
      col  = 16'($urandom % (MAX_COLLID + 3));
      impl = ($urandom % 10) < 3;
      v    = ($urandom % 10) != 0;
      le   = ($urandom % 20) == 0;
      ea   = (($urandom % 10) == 0) ? int'(1 + $urandom % 5) : 0;
      run(dev, ev, iid, col, impl, idb, v, sz, ea, le, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=below 150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule